// File: doc/BRIEF.md
# Alert Response Responder

This block is the slave-side logic that lets a device with a pending interrupt answer an alert-response query on a shared two-wire bus. It watches the bus clock and data lines through synchronizers, running on a faster system clock. It detects START and STOP conditions and decodes the first byte of each transfer. It also drives an active-low, open-drain alert line. Its outputs are pull-down enables: a 1 means the pad pulls the wire low, and a 0 means the wire is released.

The alert line is raised when the interrupt-pending input rises while the alert feature is enabled. The master then issues a read to the fixed broadcast address 0001100. If this device is holding its alert, it acknowledges that address and sends back its own 7-bit address with a 0 in the lowest bit. Several responders may transmit at the same time. The wired-AND bus settles the contest bit by bit, and the lowest address wins. The winner releases its alert. A loser stops driving the data line and keeps its alert asserted, so the master runs another query.

Top module: `smb_alert_responder`

## Requirements
- R1: After reset, both `alert_pull` and `sda_pull` are 0, so both wires are released.
- R2: `alert_pull` becomes 1 when `irq_pending` rises while `alert_en` is 1. A rising edge of `irq_pending` while `alert_en` is 0 leaves `alert_pull` at 0.
- R3: A first byte of 0x19 (address 0001100 followed by read bit 1), received while `alert_pull` is 1 and `alert_en` is 1, is acknowledged. The block pulls SDA low during the 9th clock. It only starts pulling SDA while SCL is low.
- R4: A first byte of 0x18 (address 0001100 followed by write bit 0) is not acknowledged.
- R5: A first byte of 0x19 received while `alert_pull` is 0 is not acknowledged.
- R6: A first byte that names any other address (for example 0x1B) is not acknowledged.
- R7: After the acknowledge, the block sends the byte {`own_addr`, 0}, most significant bit first. Each bit is applied while SCL is low.
- R8: If the returned byte reaches its 9th clock without a lost bit, `alert_pull` returns to 0 at the start of that 9th clock.
- R9: If the block releases SDA to send a 1 but samples SDA low on the SCL rising edge, it drives SDA no more for the rest of that transfer, and `alert_pull` stays 1.
- R10: If the master acknowledges the returned byte, each following byte reads as 0xFF until the master sends a NACK.
- R11: A STOP, or a repeated START, returns the block to idle from any state and releases SDA. A query that follows a repeated START is decoded afresh.
- R12: After a winning response, a new rising edge of `irq_pending` asserts `alert_pull` again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock wire as seen at the pad |
| sda_i | input | 1 | Bus data wire as seen at the pad |
| irq_pending | input | 1 | Interrupt-pending request; its rising edge raises the alert |
| alert_en | input | 1 | Alert feature enable |
| own_addr | input | ADDR_W | This device's bus address |
| alert_pull | output | 1 | 1 = pull the alert wire low |
| sda_pull | output | 1 | 1 = pull the data wire low |

## Verification
The query path is tried with five first bytes:
- the broadcast read with the alert held;
- the same read with no alert pending;
- the broadcast write;
- a neighbouring address;
- a query cut short by a repeated START.

Only the first of these may earn an acknowledge, and the last shows that decoding restarts. The returned byte is read three ways:
- alone on the bus, where the win must release the alert;
- against a modelled competitor with a lower address, whose pattern exposes any data bit the loser keeps driving after it lost;
- with a master acknowledge, which must produce an all-ones byte.

// File: rtl/smb_ara_pkg.sv
// Shared types for the alert-response responder.
// Assumes: nothing beyond the SystemVerilog standard.
package smb_ara_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // no transfer of interest
        ST_ADDR,   // shifting in the first byte
        ST_ACK,    // pulling SDA for the acknowledge clock
        ST_TX,     // sending own address or filler bytes
        ST_MACK,   // waiting for the master's ack or nack
        ST_SKIP    // ignoring the bus until START or STOP
    } ara_state_t;

endpackage

// File: rtl/smb_line_sync.sv
// Two-flop synchronizers for SCL and SDA, plus edge and condition detection.
// Assumes: SCL phases last several clk cycles, so one sample per phase is enough.
module smb_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_m, scl_s, scl_d;
    logic sda_m, sda_d;

    // Synchronize both wires and keep one delayed copy of each; the idle level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_m <= 1'b1; scl_s <= 1'b1; scl_d <= 1'b1;
            sda_m <= 1'b1; sda_s <= 1'b1; sda_d <= 1'b1;
        end else begin
            scl_m <= scl_i; scl_s <= scl_m; scl_d <= scl_s;
            sda_m <= sda_i; sda_s <= sda_m; sda_d <= sda_s;
        end
    end

    // Edges of SCL, and SDA transitions while SCL stays high.
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/smb_alert_latch.sv
// Holds the alert request: set by a pending-interrupt rising edge while enabled,
// cleared by a won response or by disabling the feature.
// Assumes: irq_pending is synchronous to clk.
module smb_alert_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_pending,
    input  logic alert_en,
    input  logic win,
    output logic alert_q
);

    logic irq_d;

    // Track the previous irq level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_d <= 1'b0;
        else        irq_d <= irq_pending;
    end

    // Alert state: a new event takes priority over a release in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       alert_q <= 1'b0;
        else if (!alert_en)                               alert_q <= 1'b0;
        else if (irq_pending && !irq_d)                   alert_q <= 1'b1;
        else if (win)                                     alert_q <= 1'b0;
    end

endmodule

// File: rtl/smb_ara_engine.sv
// Byte-level engine: decodes the first byte, acknowledges the broadcast read,
// returns own address with bitwise arbitration, then fills with ones until a NACK.
// Assumes: SDA is only changed on a detected SCL fall, that is, while SCL is low.
module smb_ara_engine
    import smb_ara_pkg::*;
#(
    parameter int               ADDR_W   = 7,
    parameter logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              alert_active,
    input  logic              alert_en,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              sda_pull,
    output logic              win
);

    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    ara_state_t        state;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              got_all;
    logic              first;
    logic              lost;
    logic              hit;

    // First byte matches the broadcast read and this device may answer.
    always_comb hit = (shreg == {ARA_ADDR, 1'b1}) && alert_en && alert_active;

    // Main sequencer for decoding, acknowledging, transmitting and arbitration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            bit_cnt  <= '0;
            got_all  <= 1'b0;
            first    <= 1'b0;
            lost     <= 1'b0;
            sda_pull <= 1'b0;
            win      <= 1'b0;
        end else begin
            win <= 1'b0;
            if (stop_det) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
                lost     <= 1'b0;
            end else if (start_det) begin
                state    <= ST_ADDR;
                bit_cnt  <= '0;
                got_all  <= 1'b0;
                sda_pull <= 1'b0;
                lost     <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise && !got_all) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_s};
                            if (bit_cnt == LAST) got_all <= 1'b1;
                            else                 bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && got_all) begin
                            if (hit) begin
                                state    <= ST_ACK;
                                sda_pull <= 1'b1;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            shreg    <= {own_addr, 1'b0};
                            bit_cnt  <= '0;
                            sda_pull <= ~own_addr[ADDR_W-1];
                            first    <= 1'b1;
                            state    <= ST_TX;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise && !lost && !sda_pull && !sda_s) begin
                            lost  <= 1'b1;
                            state <= ST_SKIP;
                        end else if (scl_fall) begin
                            if (bit_cnt == LAST) begin
                                sda_pull <= 1'b0;
                                win      <= first;
                                first    <= 1'b0;
                                state    <= ST_MACK;
                            end else begin
                                shreg    <= {shreg[BYTE_W-2:0], 1'b1};
                                sda_pull <= ~shreg[BYTE_W-2];
                                bit_cnt  <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise && sda_s) begin
                            state <= ST_SKIP;
                        end else if (scl_fall) begin
                            shreg    <= '1;
                            bit_cnt  <= '0;
                            sda_pull <= 1'b0;
                            state    <= ST_TX;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/smb_alert_responder.sv
// Top of the alert-response responder: synchronizer, alert latch and byte engine.
// Assumes: outputs feed open-drain pads (1 = pull low); clk oversamples SCL.
module smb_alert_responder #(
    parameter int               ADDR_W   = 7,
    parameter logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              irq_pending,
    input  logic              alert_en,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              alert_pull,
    output logic              sda_pull
);

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic win;

    smb_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_alert_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_pending (irq_pending),
        .alert_en    (alert_en),
        .win         (win),
        .alert_q     (alert_pull)
    );

    smb_ara_engine #(.ADDR_W(ADDR_W), .ARA_ADDR(ARA_ADDR)) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .sda_s        (sda_s),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .alert_active (alert_pull),
        .alert_en     (alert_en),
        .own_addr     (own_addr),
        .sda_pull     (sda_pull),
        .win          (win)
    );

endmodule

// File: rtl/smb_alert_responder_chk.sv
// Checker for the alert-response responder, attached by bind.
// Assumes: the bound instance exposes the engine's win and lost signals.
module smb_alert_responder_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic irq_pending,
    input logic alert_en,
    input logic alert_pull,
    input logic sda_pull,
    input logic win,
    input logic lost,
    input logic stop_det
);

    // R1: outputs are never unknown once out of reset
    assert_outputs_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({alert_pull, sda_pull}));

    // R2: alert only rises when the enable was set
    assert_alert_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert_pull) |-> $past(alert_en));

    // R3: SDA pull only begins while SCL is low
    assert_pull_starts_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_i);

    // R8: a won response releases the alert unless a new request is pending
    assert_win_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (win && !irq_pending) |=> !alert_pull);

    // R9: after a lost bit the block does not drive SDA
    assert_lost_no_pull_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lost |-> !sda_pull);

    // R11: a STOP releases SDA on the next cycle
    assert_stop_releases_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull);

endmodule

bind smb_alert_responder smb_alert_responder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .irq_pending (irq_pending),
    .alert_en    (alert_en),
    .alert_pull  (alert_pull),
    .sda_pull    (sda_pull),
    .win         (win),
    .lost        (u_eng.lost),
    .stop_det    (stop_det)
);

// File: tb/smb_alert_responder_test.sv
// Scoreboard bench: read tasks push expected bytes, a monitor compares them.
module smb_alert_responder_test;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 10;   // clk cycles per quarter SCL period

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       oth_pull = 1'b0;
    logic       irq = 1'b0;
    logic       en = 1'b0;
    logic [6:0] own = 7'h2C;
    logic       alert_pull, sda_pull;
    wire        sda_line = m_sda & ~sda_pull & ~oth_pull;

    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;
    exp_t       exp_q[$];
    logic [7:0] got_byte;
    event       got_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_alert_responder uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (sda_line),
        .irq_pending (irq),
        .alert_en    (en),
        .own_addr    (own),
        .alert_pull  (alert_pull),
        .sda_pull    (sda_pull)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_q(input int n = 1);
        repeat (n * QTR) @(negedge clk);
    endtask

    task automatic clock_bit(input logic m, input logic o, output logic smp);
        m_sda    = m;
        oth_pull = ~o;
        wait_q();
        m_scl = 1'b1;
        wait_q();
        smp = sda_line;
        wait_q();
        m_scl = 1'b0;
        wait_q();
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; oth_pull = 1'b0; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b1; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], 1'b1, s);
        clock_bit(1'b1, 1'b1, s);
        acked = !s;
    endtask

    // Driver: pushes the expected byte, then clocks it in, optionally against a competitor.
    task automatic read_byte(input logic [7:0] oth, input bit mack,
                             input logic [7:0] expv, input string req);
        logic       s;
        logic [7:0] v;
        exp_t       e;
        e.val = expv;
        e.req = req;
        exp_q.push_back(e);
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, oth[i], s);
            v[i] = s;
        end
        clock_bit(mack ? 1'b0 : 1'b1, 1'b1, s);
        got_byte = v;
        ->got_ev;
    endtask

    task automatic pulse_irq();
        irq = 1'b1; repeat (3) @(negedge clk);
        irq = 1'b0; repeat (3) @(negedge clk);
    endtask

    // Monitor: pops expected bytes and compares them with what the bus delivered.
    initial begin
        forever begin
            exp_t e;
            @(got_ev);
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected byte", got_byte, 0);
            end else begin
                e = exp_q.pop_front();
                check(got_byte == e.val, e.req, "returned byte", got_byte, e.val);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit ack;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state
        check(alert_pull == 1'b0, "R1", "alert after reset", alert_pull, 0);
        check(sda_pull == 1'b0, "R1", "sda after reset", sda_pull, 0);

        // R2: disabled feature ignores the request
        pulse_irq();
        check(alert_pull == 1'b0, "R2", "alert with enable low", alert_pull, 0);

        // R5: broadcast read with no alert held
        bus_start();
        send_byte(8'h19, ack);
        check(!ack, "R5", "ack without alert", ack, 0);
        bus_stop();

        // R2: enabled request raises the alert
        en = 1'b1;
        pulse_irq();
        check(alert_pull == 1'b1, "R2", "alert with enable high", alert_pull, 1);

        // R4: broadcast write is not acknowledged
        bus_start();
        send_byte(8'h18, ack);
        check(!ack, "R4", "ack on write", ack, 0);
        bus_stop();
        check(alert_pull == 1'b1, "R4", "alert kept after write", alert_pull, 1);

        // R6: other address is not acknowledged
        bus_start();
        send_byte(8'h1B, ack);
        check(!ack, "R6", "ack on other address", ack, 0);
        bus_stop();

        // R3, R7, R8: query alone on the bus
        bus_start();
        send_byte(8'h19, ack);
        check(ack, "R3", "ack on broadcast read", ack, 1);
        read_byte(8'hFF, 1'b0, {own, 1'b0}, "R7");
        check(alert_pull == 1'b0, "R8", "alert after win", alert_pull, 0);
        bus_stop();

        // R12: new request after a win
        pulse_irq();
        check(alert_pull == 1'b1, "R12", "alert re-asserted", alert_pull, 1);

        // R9: lower competitor address 0x26 wins; bus shows its byte 0x4C
        bus_start();
        send_byte(8'h19, ack);
        check(ack, "R3", "ack before contest", ack, 1);
        read_byte(8'h4C, 1'b0, 8'h4C, "R9");
        check(alert_pull == 1'b1, "R9", "alert kept after loss", alert_pull, 1);
        bus_stop();
        check(sda_pull == 1'b0, "R11", "sda after stop", sda_pull, 0);

        // R11: repeated START mid-byte, then a fresh query; R10: master ack gives 0xFF
        bus_start();
        begin
            logic s;
            clock_bit(1'b0, 1'b1, s);
            clock_bit(1'b1, 1'b1, s);
            clock_bit(1'b1, 1'b1, s);
        end
        bus_start();
        send_byte(8'h19, ack);
        check(ack, "R11", "ack after repeated start", ack, 1);
        read_byte(8'hFF, 1'b1, {own, 1'b0}, "R7");
        check(alert_pull == 1'b0, "R8", "alert after acked win", alert_pull, 0);
        read_byte(8'hFF, 1'b0, 8'hFF, "R10");
        bus_stop();
        check(sda_pull == 1'b0, "R11", "sda after final stop", sda_pull, 0);
        check(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule